// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block links two 8-bit buses, A and B. It has one storage register for each direction. Each bus appears as three separate signals: an input, an output and an output enable. No tri-state nets are needed, and a pad ring or bus fabric can combine the three signals outside the block. At most one bus is driven at a time. The side that is not driven is treated as an input.

An active-low enable turns all driving on or off, and a direction input picks which bus is driven. A source select for each direction decides what the driven bus carries: live data passed straight through from the opposite bus, or the value held in that direction's register. Each register has its own capture strobe. The strobes are sampled on the block clock, and a register loads on a low-to-high change of its strobe. Loading happens whatever the enable and direction inputs are set to, so data can be latched while both buses are isolated.

Top module: `bxr_xcvr`

## Requirements
- R1: While `rst_ni` is low, and after it is released, both stored values are zero until the first capture.
- R2: On a clock edge where `cap_ab_i` is 1 and was 0 at the previous edge, the A-to-B register loads `a_i`. A strobe held high loads only once. With no such rise, the register keeps its value.
- R3: On a clock edge where `cap_ba_i` is 1 and was 0 at the previous edge, the B-to-A register loads `b_i`. With no such rise, the register keeps its value.
- R4: Capture takes place for any value of `oe_ni` and `dir_i`, including isolation.
- R5: When both strobes rise at the same edge, each register loads from its own input bus.
- R6: With `oe_ni` = 1, `a_oe_o` and `b_oe_o` are both 0.
- R7: With `oe_ni` = 0, `dir_i` = 0 drives bus A (`a_oe_o` = 1, `b_oe_o` = 0), and `dir_i` = 1 drives bus B (`b_oe_o` = 1, `a_oe_o` = 0).
- R8: While A is driven, `sel_ba_i` = 0 gives `a_o` = `b_i` combinationally, in the same cycle.
- R9: While A is driven, `sel_ba_i` = 1 gives `a_o` = the stored B-to-A value.
- R10: While B is driven, `sel_ab_i` = 0 gives `b_o` = `a_i`, and `sel_ab_i` = 1 gives `b_o` = the stored A-to-B value.
- R11: `a_oe_o` and `b_oe_o` are never 1 together.
- R12: The data output of a bus that is not driven is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock; strobes are sampled on its rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| oe_ni | input | 1 | Output enable, active low |
| dir_i | input | 1 | 0: drive bus A, 1: drive bus B |
| cap_ab_i | input | 1 | Capture strobe for the A-to-B register |
| cap_ba_i | input | 1 | Capture strobe for the B-to-A register |
| sel_ab_i | input | 1 | Source for bus B: 0 live A, 1 stored A-to-B |
| sel_ba_i | input | 1 | Source for bus A: 0 live B, 1 stored B-to-A |
| a_i | input | 8 | Bus A input data |
| a_o | output | 8 | Bus A output data |
| a_oe_o | output | 1 | Bus A driver enable |
| b_i | input | 8 | Bus B input data |
| b_o | output | 8 | Bus B output data |
| b_oe_o | output | 1 | Bus B driver enable |

## Verification
The embedded properties check on every cycle that at most one bus is enabled, that isolation clears both enables, that a bus which is not driven shows zero, and that a live path copies the opposite bus. They also check that a register loads on a strobe rise and holds its value otherwise. Several behaviours can only be shown by the bench's scenarios: the stored value seen at the output after a capture made during isolation, a held strobe loading exactly once, simultaneous captures going to the right registers, and the zero value after reset.

// File: rtl/bxr_pkg.sv
package bxr_pkg;
  typedef enum logic [1:0] {
    DRV_NONE = 2'd0,
    DRV_A    = 2'd1,
    DRV_B    = 2'd2
  } drive_e;
endpackage

// File: rtl/bxr_capture.sv
module bxr_capture #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         strobe_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic         strobe_q;
  logic         rise;
  logic [W-1:0] data_q;

  assign rise = strobe_i & ~strobe_q;
  assign q_o  = data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strobe_q <= 1'b0;
      data_q   <= '0;
    end else begin
      strobe_q <= strobe_i;
      if (rise) data_q <= d_i;
    end
  end

  AST_LOAD_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && !strobe_q) |=> (q_o == $past(d_i)));  // R2

  AST_HOLD_NO_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(strobe_i && !strobe_q) |=> $stable(q_o));  // R3
endmodule

// File: rtl/bxr_route.sv
module bxr_route
  import bxr_pkg::*;
(
  input  logic   oe_ni,
  input  logic   dir_i,
  output drive_e drive_o
);
  always_comb begin
    if (oe_ni)      drive_o = DRV_NONE;
    else if (dir_i) drive_o = DRV_B;
    else            drive_o = DRV_A;
  end
endmodule

// File: rtl/bxr_out_sel.sv
module bxr_out_sel #(
  parameter int W = 8
) (
  input  logic         en_i,
  input  logic         use_stored_i,
  input  logic [W-1:0] live_i,
  input  logic [W-1:0] stored_i,
  output logic [W-1:0] data_o
);
  always_comb begin
    if (!en_i)             data_o = '0;
    else if (use_stored_i) data_o = stored_i;
    else                   data_o = live_i;
  end
endmodule

// File: rtl/bxr_xcvr.sv
module bxr_xcvr
  import bxr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              oe_ni,
  input  logic              dir_i,
  input  logic              cap_ab_i,
  input  logic              cap_ba_i,
  input  logic              sel_ab_i,
  input  logic              sel_ba_i,
  input  logic [DATA_W-1:0] a_i,
  output logic [DATA_W-1:0] a_o,
  output logic              a_oe_o,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] b_o,
  output logic              b_oe_o
);
  drive_e            drive;
  logic [DATA_W-1:0] ab_q;
  logic [DATA_W-1:0] ba_q;

  bxr_capture #(.W(DATA_W)) u_cap_ab (
    .clk_i(clk_i), .rst_ni(rst_ni), .strobe_i(cap_ab_i), .d_i(a_i), .q_o(ab_q)
  );

  bxr_capture #(.W(DATA_W)) u_cap_ba (
    .clk_i(clk_i), .rst_ni(rst_ni), .strobe_i(cap_ba_i), .d_i(b_i), .q_o(ba_q)
  );

  bxr_route u_route (.oe_ni(oe_ni), .dir_i(dir_i), .drive_o(drive));

  assign a_oe_o = (drive == DRV_A);
  assign b_oe_o = (drive == DRV_B);

  bxr_out_sel #(.W(DATA_W)) u_sel_a (
    .en_i(a_oe_o), .use_stored_i(sel_ba_i), .live_i(b_i), .stored_i(ba_q), .data_o(a_o)
  );

  bxr_out_sel #(.W(DATA_W)) u_sel_b (
    .en_i(b_oe_o), .use_stored_i(sel_ab_i), .live_i(a_i), .stored_i(ab_q), .data_o(b_o)
  );

  AST_ONE_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({a_oe_o, b_oe_o}));  // R11

  AST_ISOLATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> (!a_oe_o && !b_oe_o));  // R6

  AST_A_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_oe_o && !sel_ba_i) |-> (a_o == b_i));  // R8

  AST_B_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (b_oe_o && !sel_ab_i) |-> (b_o == a_i));  // R10

  AST_A_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !a_oe_o |-> (a_o == '0));  // R12

  AST_B_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !b_oe_o |-> (b_o == '0));  // R12
endmodule

// File: tb/bxr_xcvr_test.sv
module bxr_xcvr_test;
  localparam int W = 8;
  localparam int NV = 8;
  localparam int VW = 4 + 4*W + 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic oe_ni = 1'b1, dir_i = 1'b0, cap_ab_i = 1'b0, cap_ba_i = 1'b0;
  logic sel_ab_i = 1'b0, sel_ba_i = 1'b0;
  logic [W-1:0] a_i = '0, b_i = '0;
  logic [W-1:0] a_o, b_o;
  logic a_oe_o, b_oe_o;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  bxr_xcvr #(.DATA_W(W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .oe_ni(oe_ni), .dir_i(dir_i),
    .cap_ab_i(cap_ab_i), .cap_ba_i(cap_ba_i), .sel_ab_i(sel_ab_i), .sel_ba_i(sel_ba_i),
    .a_i(a_i), .a_o(a_o), .a_oe_o(a_oe_o), .b_i(b_i), .b_o(b_o), .b_oe_o(b_oe_o)
  );

  // {oe_n, dir, sel_ab, sel_ba, a, b, exp_a_oe, exp_b_oe, exp_a, exp_b}; stored ab=3C, ba=C3
  localparam logic [VW-1:0] VEC [NV] = '{
    {1'b1, 1'b0, 1'b0, 1'b0, 8'h11, 8'h22, 1'b0, 1'b0, 8'h00, 8'h00},
    {1'b0, 1'b0, 1'b0, 1'b0, 8'h11, 8'h22, 1'b1, 1'b0, 8'h22, 8'h00},
    {1'b0, 1'b0, 1'b0, 1'b1, 8'h11, 8'h22, 1'b1, 1'b0, 8'hC3, 8'h00},
    {1'b0, 1'b1, 1'b0, 1'b0, 8'h11, 8'h22, 1'b0, 1'b1, 8'h00, 8'h11},
    {1'b0, 1'b1, 1'b1, 1'b0, 8'h11, 8'h22, 1'b0, 1'b1, 8'h00, 8'h3C},
    {1'b0, 1'b0, 1'b1, 1'b0, 8'hFF, 8'h00, 1'b1, 1'b0, 8'h00, 8'h00},
    {1'b1, 1'b1, 1'b1, 1'b1, 8'hFF, 8'hEE, 1'b0, 1'b0, 8'h00, 8'h00},
    {1'b0, 1'b1, 1'b0, 1'b1, 8'hA5, 8'h5A, 1'b0, 1'b1, 8'h00, 8'hA5}
  };

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic set_view(input logic oe_n, input logic dir, input logic sab, input logic sba);
    oe_ni = oe_n; dir_i = dir; sel_ab_i = sab; sel_ba_i = sba;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected<=5000", cycles);
      finish_run();
    end
  end

  initial begin
    // R1: held reset, stored B-to-A visible on A
    b_i = 8'h5A; set_view(1'b0, 1'b0, 1'b1, 1'b1);
    repeat (2) @(negedge clk);
    #1 check("R1 stored ba in reset", a_o, 8'h00);
    @(negedge clk); rst_ni = 1'b1;
    @(negedge clk); #1 check("R1 stored ba after reset", a_o, 8'h00);
    dir_i = 1'b1; a_i = 8'h66;
    #1 check("R1 stored ab after reset", b_o, 8'h00);

    // R4: load both while isolated
    @(negedge clk);
    set_view(1'b1, 1'b1, 1'b0, 1'b0);
    a_i = 8'h3C; cap_ab_i = 1'b1;
    @(negedge clk); cap_ab_i = 1'b0;
    dir_i = 1'b0; b_i = 8'hC3; cap_ba_i = 1'b1;
    @(negedge clk); cap_ba_i = 1'b0;
    a_i = 8'h00; b_i = 8'h00;
    #1 check("R6 a_oe isolated", {7'b0, a_oe_o}, 8'h00);
    check("R6 b_oe isolated", {7'b0, b_oe_o}, 8'h00);

    // vector table: R6 R7 R8 R9 R10 R11 R12
    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      @(negedge clk);
      set_view(v[37], v[36], v[35], v[34]);
      a_i = v[33:26]; b_i = v[25:18];
      #1;
      check($sformatf("R7 vec%0d a_oe", i), {7'b0, a_oe_o}, {7'b0, v[17]});
      check($sformatf("R7 vec%0d b_oe", i), {7'b0, b_oe_o}, {7'b0, v[16]});
      check($sformatf("R11 vec%0d oe both", i), {7'b0, a_oe_o & b_oe_o}, 8'h00);
      check($sformatf("R9 R8 R12 vec%0d a_o", i), a_o, v[15:8]);
      check($sformatf("R10 R12 vec%0d b_o", i), b_o, v[7:0]);
    end

    // R8: live path follows same cycle, between clock edges
    @(negedge clk); set_view(1'b0, 1'b0, 1'b0, 1'b0); b_i = 8'h01;
    #1 check("R8 live a first", a_o, 8'h01);
    #2 b_i = 8'h80;
    #1 check("R8 live a mid-cycle", a_o, 8'h80);

    // R2: held strobe loads once, while B is driven (R4)
    @(negedge clk); set_view(1'b0, 1'b1, 1'b1, 1'b0);
    a_i = 8'h77; cap_ab_i = 1'b1;
    @(negedge clk); a_i = 8'h88;
    @(negedge clk); cap_ab_i = 1'b0; a_i = 8'h99;
    @(negedge clk); #1 check("R2 held strobe loads once", b_o, 8'h77);

    // R3: no strobe, B-to-A register holds
    @(negedge clk); set_view(1'b0, 1'b0, 1'b0, 1'b1); b_i = 8'h44;
    @(negedge clk); #1 check("R3 hold without strobe", a_o, 8'hC3);
    cap_ba_i = 1'b1;
    @(negedge clk); cap_ba_i = 1'b0; b_i = 8'h00;
    #1 check("R3 load b", a_o, 8'h44);

    // R5: simultaneous strobes
    @(negedge clk); set_view(1'b1, 1'b0, 1'b0, 1'b0);
    a_i = 8'h12; b_i = 8'h34; cap_ab_i = 1'b1; cap_ba_i = 1'b1;
    @(negedge clk); cap_ab_i = 1'b0; cap_ba_i = 1'b0; a_i = 8'h00; b_i = 8'h00;
    set_view(1'b0, 1'b1, 1'b1, 1'b1);
    #1 check("R5 ab from a", b_o, 8'h12);
    dir_i = 1'b0;
    #1 check("R5 ba from b", a_o, 8'h34);

    // R1: async reset clears stored values
    @(negedge clk); rst_ni = 1'b0;
    #1 check("R1 clear by reset", a_o, 8'h00);
    @(negedge clk); rst_ni = 1'b1;
    @(negedge clk); dir_i = 1'b1;
    #1 check("R1 ab cleared", b_o, 8'h00);

    finish_run();
  end
endmodule